// File: doc/BRIEF.md
# Serial DAC load and update controller

This block is the digital front end of a voltage-output converter whose data path is `DATA_W` bits wide (16 by default). A host shifts one word per frame over a three-wire serial port. The frame pin is held low for the whole frame. Data is sampled on each falling edge of the serial clock, most significant bit first. When the frame pin returns high, a frame of exactly `DATA_W` bits is stored in an input register. A frame of any other length is thrown away.

A second stage, the DAC register, holds the code that the converter presents. It takes a new value in one of two ways:

- from the input register, on a falling edge of the load pin;
- directly from a completed frame, if the load pin is already low when that frame ends.

Two active-low overrides decide what the output shows:

- **Power-down** has the highest priority. It forces the output to zero.
- **Clear** forces the output to zero. After clear is released, the output stays at zero until the next load.

While either override is active, both registers can still be written. All pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and every register update is driven by an edge detector on the synchronized pins. The output is modelled as a signed digital value equal to the held code minus mid-scale. A serial data output carries the top bit of the shift register, so several devices can be chained.

Top module: `sdac_frontend`

## Requirements
- R1: Bits are sampled on a falling edge of `sclk_i` only while `frame_n_i` is low, most significant bit first. When `frame_n_i` rises after exactly `DATA_W` bits, the word is stored in the input register. A later load strobe makes the stored word visible on `dac_code_o`.
- R2: A frame whose bit count differs from `DATA_W` (fewer or more bits) leaves the input register unchanged.
- R3: If `load_n_i` is high when a frame completes, `dac_code_o` keeps its previous value. A later falling edge of `load_n_i` copies the input register into the DAC register.
- R4: If `load_n_i` is low when a valid frame completes, the new word goes straight into the DAC register and appears on `dac_code_o`.
- R5: While `clear_n_i` is low, `out_zero_o` is 1 and `out_value_o` is 0. Frames and load strobes still update `dac_code_o` during this time.
- R6: After `clear_n_i` returns high, the output stays forced to zero until either a falling edge of `load_n_i` or a valid frame that completes while `load_n_i` is low.
- R7: While `pwr_up_i` is low, `pwr_down_o` is 1, `out_zero_o` is 1 and `out_value_o` is 0, whatever the state of clear and load. Both registers remain writable. When `pwr_up_i` returns high and no clear is pending, the output shows the held code again.
- R8: When the output is not forced to zero, `out_value_o` equals `dac_code_o` minus 2^(DATA_W-1), as a two's-complement value. For 16 bits: 0xFFFF gives 32767, 0x8000 gives 0, 0x7FFF gives -1, and 0x0000 gives -32768.
- R9: Out of reset, `dac_code_o` is 0x8000, `out_zero_o` is 1 and `out_value_o` is 0.
- R10: `sdata_o` is the top bit of the shift register. After a full frame it equals the first bit sent. During a following frame, k shifts later, it equals bit `DATA_W-1-k` of the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n_i | input | 1 | Active-low frame enable for the serial port |
| sclk_i | input | 1 | Serial clock; data is sampled on its falling edge |
| sdata_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Active-low load strobe for the DAC register |
| clear_n_i | input | 1 | Active-low clear; forces the output to zero |
| pwr_up_i | input | 1 | Power enable; low selects power-down |
| sdata_o | output | 1 | Serial data out for chaining |
| dac_code_o | output | DATA_W | Code held in the DAC register |
| out_zero_o | output | 1 | Output is forced to zero |
| pwr_down_o | output | 1 | Device is in power-down |
| out_value_o | output | DATA_W | Signed output value (code minus mid-scale) |

## Verification
The bench goes after the corner cases where the three layers of output control interact.

- **Frames written during clear or power-down.** A design that blocks these writes would show a stale `dac_code_o` once the override is lifted.
- **Releasing clear with no load.** A design that lets the output spring back to the held code when clear is released would show a nonzero value too early.
- **Short and long frames.** Both are followed by a load strobe. A design that stores wrongly counted words would change the code.
- **Daisy-chain output.** `sdata_o` is sampled partway into a discarded frame. An off-by-one in the shift path would expose the wrong bit of the previous word.
- **Offset-binary end points.** Checking the four end-point codes catches a missing or misplaced sign flip.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

   // Synchronized view of the asynchronous pins, in a fixed packing order.
   typedef struct packed {
      logic frame_n;
      logic sclk;
      logic din;
      logic load_n;
      logic clear_n;
      logic pwr_up;
   } pins_t;

   localparam int PIN_N = $bits(pins_t);

   // Idle levels loaded into the synchronizers during reset.
   localparam pins_t PIN_IDLE = '{frame_n: 1'b1, sclk: 1'b0, din: 1'b0,
                                  load_n: 1'b1, clear_n: 1'b1, pwr_up: 1'b1};

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int             WIDTH  = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] level_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("sdac_sync: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic meta_q;
      logic stab_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= RST_VAL[i];
            stab_q <= RST_VAL[i];
         end else begin
            meta_q <= async_i[i];
            stab_q <= meta_q;
         end
      end

      assign level_o[i] = stab_q;
   end

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_lvl,
   input  logic              frame_fall,
   input  logic              frame_rise,
   input  logic              sclk_fall,
   input  logic              din,
   output logic              sdo,
   output logic [DATA_W-1:0] word_o,
   output logic              word_valid_o
);

   // Counter saturates one past a full frame, so long frames stay invalid.
   localparam int CNT_MAX = DATA_W + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   logic [DATA_W-1:0] shreg_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
      end else if (frame_fall) begin
         cnt_q <= '0;
      end else if (sclk_fall && !frame_lvl) begin
         shreg_q <= {shreg_q[DATA_W-2:0], din};
         if (cnt_q != CNT_W'(CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_valid_o <= 1'b0;
      end else begin
         word_valid_o <= frame_rise && (cnt_q == CNT_W'(DATA_W));
      end
   end

   // The shift register is frozen while the frame pin is high, so the word
   // is still intact in the cycle when the valid pulse fires.
   assign word_o = shreg_q;
   assign sdo    = shreg_q[DATA_W-1];

   // Only a frame with exactly DATA_W bits produces a word.
   assert_frame_len_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> $past(cnt_q) == CNT_W'(DATA_W))
      else $error("word accepted with wrong bit count");

   // Each shift moves the next lower bit to the chain output.
   assert_chain_out_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_fall && !frame_lvl && !frame_fall) |=> sdo == $past(shreg_q[DATA_W-2]))
      else $error("chain output did not advance");

endmodule

// File: rtl/sdac_update.sv
module sdac_update #(
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DATA_W-1:0]        word_i,
   input  logic                     word_valid_i,
   input  logic                     load_lvl,
   input  logic                     load_fall,
   input  logic                     clear_lvl,
   input  logic                     pwr_lvl,
   output logic [DATA_W-1:0]        code_o,
   output logic                     forced_zero_o,
   output logic                     powered_down_o,
   output logic signed [DATA_W-1:0] value_o
);

   localparam logic [DATA_W-1:0] MID   = {1'b1, {(DATA_W-1){1'b0}}};
   localparam int                MID_I = 2 ** (DATA_W - 1);

   logic [DATA_W-1:0] inp_q;
   logic [DATA_W-1:0] dac_q;
   logic              zeroed_q;
   logic              direct_ld;

   // A valid frame that ends while the load pin is low writes both registers.
   assign direct_ld = word_valid_i && !load_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inp_q <= MID;
         dac_q <= MID;
      end else begin
         if (word_valid_i) begin
            inp_q <= word_i;
         end
         if (direct_ld) begin
            dac_q <= word_i;
         end else if (load_fall) begin
            dac_q <= inp_q;
         end
      end
   end

   // Clear latch: set while clear is low, released only by the next load.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zeroed_q <= 1'b1;
      end else if (!clear_lvl) begin
         zeroed_q <= 1'b1;
      end else if (load_fall || direct_ld) begin
         zeroed_q <= 1'b0;
      end
   end

   assign code_o         = dac_q;
   assign powered_down_o = !pwr_lvl;
   assign forced_zero_o  = zeroed_q || !pwr_lvl;
   assign value_o        = forced_zero_o ? '0 : {~dac_q[DATA_W-1], dac_q[DATA_W-2:0]};

   assert_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!word_valid_i && !load_fall) |=> $stable(dac_q))
      else $error("DAC register changed without a load");

   assert_strobe_copy_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (load_fall && !word_valid_i) |=> dac_q == $past(inp_q))
      else $error("load strobe did not copy the input register");

   assert_direct_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_i && !load_lvl) |=> dac_q == $past(word_i))
      else $error("direct load missed");

   assert_clear_zero_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !clear_lvl |=> forced_zero_o && value_o == '0)
      else $error("clear did not force zero");

   assert_release_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (zeroed_q && !load_fall && !direct_ld) |=> zeroed_q)
      else $error("clear latch released without a load");

   assert_pd_zero_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_lvl |-> (value_o == '0 && powered_down_o))
      else $error("power-down did not force zero");

   assert_offset_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !forced_zero_o |-> int'(value_o) == int'(code_o) - MID_I)
      else $error("offset-binary mapping wrong");

endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_n_i,
   input  logic                     sclk_i,
   input  logic                     sdata_i,
   input  logic                     load_n_i,
   input  logic                     clear_n_i,
   input  logic                     pwr_up_i,
   output logic                     sdata_o,
   output logic [DATA_W-1:0]        dac_code_o,
   output logic                     out_zero_o,
   output logic                     pwr_down_o,
   output logic signed [DATA_W-1:0] out_value_o
);
   import sdac_pkg::*;

   if (DATA_W < 4 || DATA_W > 30) begin : g_bad_width
      $error("sdac_frontend: DATA_W must lie in 4..30");
   end

   pins_t raw_s;
   pins_t lvl_s;
   logic  frame_prev_q, sclk_prev_q, load_prev_q;
   logic  frame_fall, frame_rise, sclk_fall, load_fall;
   logic [DATA_W-1:0] word_s;
   logic              word_valid_s;

   assign raw_s.frame_n = frame_n_i;
   assign raw_s.sclk    = sclk_i;
   assign raw_s.din     = sdata_i;
   assign raw_s.load_n  = load_n_i;
   assign raw_s.clear_n = clear_n_i;
   assign raw_s.pwr_up  = pwr_up_i;

   sdac_sync #(.WIDTH(PIN_N), .RST_VAL(PIN_IDLE)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_s),
      .level_o (lvl_s)
   );

   // Edge detection on the pins that trigger register updates.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_prev_q <= PIN_IDLE.frame_n;
         sclk_prev_q  <= PIN_IDLE.sclk;
         load_prev_q  <= PIN_IDLE.load_n;
      end else begin
         frame_prev_q <= lvl_s.frame_n;
         sclk_prev_q  <= lvl_s.sclk;
         load_prev_q  <= lvl_s.load_n;
      end
   end

   assign frame_fall = frame_prev_q && !lvl_s.frame_n;
   assign frame_rise = !frame_prev_q && lvl_s.frame_n;
   assign sclk_fall  = sclk_prev_q && !lvl_s.sclk;
   assign load_fall  = load_prev_q && !lvl_s.load_n;

   sdac_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_lvl    (lvl_s.frame_n),
      .frame_fall   (frame_fall),
      .frame_rise   (frame_rise),
      .sclk_fall    (sclk_fall),
      .din          (lvl_s.din),
      .sdo          (sdata_o),
      .word_o       (word_s),
      .word_valid_o (word_valid_s)
   );

   sdac_update #(.DATA_W(DATA_W)) u_update (
      .clk            (clk),
      .rst_n          (rst_n),
      .word_i         (word_s),
      .word_valid_i   (word_valid_s),
      .load_lvl       (lvl_s.load_n),
      .load_fall      (load_fall),
      .clear_lvl      (lvl_s.clear_n),
      .pwr_lvl        (lvl_s.pwr_up),
      .code_o         (dac_code_o),
      .forced_zero_o  (out_zero_o),
      .powered_down_o (pwr_down_o),
      .value_o        (out_value_o)
   );

   // Bits are only sampled inside a frame.
   assert_no_shift_idle_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_s.frame_n && !frame_rise) |=> $stable(sdata_o))
      else $error("shift register moved outside a frame");

endmodule

// File: tb/test_sdac_frontend.sv
module test_sdac_frontend;

   localparam int W = 16;

   typedef struct {
      string        req;
      logic [W-1:0] code;
      logic         zero;
      logic         pd;
      int           value;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
   logic load_n = 1'b1, clear_n = 1'b1, pwr_up = 1'b1;
   logic                sdout, zero_o, pd_o;
   logic [W-1:0]        code_o;
   logic signed [W-1:0] value_o;

   int   n_vec = 0;
   int   n_bad = 0;
   bit   ended = 1'b0;
   exp_t sb_q[$];

   // Reference model state, written from the requirements.
   logic [W-1:0] inp_m = 16'h8000;
   logic [W-1:0] dac_m = 16'h8000;
   bit           zero_m = 1'b1;

   always #10 clk = ~clk;

   sdac_frontend #(.DATA_W(W)) i_sdac_frontend (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_n_i   (frame_n),
      .sclk_i      (sclk),
      .sdata_i     (sdin),
      .load_n_i    (load_n),
      .clear_n_i   (clear_n),
      .pwr_up_i    (pwr_up),
      .sdata_o     (sdout),
      .dac_code_o  (code_o),
      .out_zero_o  (zero_o),
      .pwr_down_o  (pd_o),
      .out_value_o (value_o)
   );

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(string req);
      exp_t e;
      e.req   = req;
      e.code  = dac_m;
      e.pd    = !pwr_up;
      e.zero  = zero_m || !pwr_up;
      e.value = e.zero ? 0 : int'(dac_m) - 32768;
      sb_q.push_back(e);
      tick(3);
   endtask

   task automatic check_sdo(string req, logic exp);
      n_vec++;
      if (sdout !== exp) begin
         n_bad++;
         $display("FAIL %s sdata_o actual %b expected %b", req, sdout, exp);
      end
   endtask

   // Monitor: pop expected items and compare against the outputs.
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (code_o !== e.code || zero_o !== e.zero || pd_o !== e.pd ||
                int'(value_o) != e.value) begin
               n_bad++;
               $display("FAIL %s actual code=%h zero=%b pd=%b val=%0d expected code=%h zero=%b pd=%b val=%0d",
                        e.req, code_o, zero_o, pd_o, int'(value_o),
                        e.code, e.zero, e.pd, e.value);
            end
         end
      end
   end

   task automatic shift_bits(logic [31:0] bits, int n);
      for (int i = n - 1; i >= 0; i--) begin
         sdin = bits[i];
         sclk = 1'b1;
         tick(4);
         sclk = 1'b0;
         tick(4);
      end
   endtask

   task automatic send(logic [31:0] bits, int n);
      frame_n = 1'b0;
      tick(6);
      shift_bits(bits, n);
      frame_n = 1'b1;
      tick(6);
      if (n == W) begin
         inp_m = bits[W-1:0];
         if (!load_n) begin
            dac_m = bits[W-1:0];
            if (clear_n) zero_m = 1'b0;
         end
      end
   endtask

   task automatic strobe_load();
      load_n = 1'b0;
      tick(6);
      dac_m = inp_m;
      if (clear_n) zero_m = 1'b0;
      load_n = 1'b1;
      tick(6);
   endtask

   task automatic set_clear(logic v);
      clear_n = v;
      if (!v) zero_m = 1'b1;
      tick(6);
   endtask

   task automatic set_pwr(logic v);
      pwr_up = v;
      tick(6);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(2);
      expect_out("R9");                         // reset state

      send(32'h1234, W);
      expect_out("R3");                         // load high: DAC unchanged
      check_sdo("R10", 1'b0);                   // first bit of 0x1234
      strobe_load();
      expect_out("R1");                         // word reaches DAC on strobe

      load_n = 1'b0;
      tick(6);
      send(32'hFFFF, W);
      expect_out("R4");                         // direct load, 32767 (R8)
      send(32'h8000, W);
      expect_out("R8");
      send(32'h7FFF, W);
      expect_out("R8");
      send(32'h0000, W);
      expect_out("R8");
      load_n = 1'b1;
      tick(6);

      send(32'h5A3C, W);
      check_sdo("R10", 1'b0);
      frame_n = 1'b0;
      tick(6);
      shift_bits(32'h7, 3);
      check_sdo("R10", 1'b1);                   // bit 12 of 0x5A3C
      frame_n = 1'b1;
      tick(6);                                  // short frame discarded
      strobe_load();
      expect_out("R2");
      send(32'h1_0001, W + 1);                  // long frame discarded
      strobe_load();
      expect_out("R2");

      set_clear(1'b0);
      expect_out("R5");
      load_n = 1'b0;
      tick(6);
      send(32'h4000, W);                        // written during clear
      expect_out("R5");
      load_n = 1'b1;
      tick(6);
      set_clear(1'b1);
      expect_out("R6");                         // still zero after release
      send(32'h6000, W);
      expect_out("R6");
      strobe_load();
      expect_out("R6");                         // released by load

      set_pwr(1'b0);
      expect_out("R7");
      send(32'h2222, W);
      strobe_load();
      expect_out("R7");                         // writable while powered down
      set_pwr(1'b1);
      expect_out("R7");

      tick(4);
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!ended) begin
         ended = 1'b1;
         n_bad++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule